// File: doc/BRIEF.md
# Configuration Stream Packet Processor

This block interprets a stream of 32-bit configuration words, one word per cycle when `in_valid_i` is high. It ignores everything until it sees the synchronisation word. After that it decodes packet headers and steers the data words that follow each header into a small bank of configuration registers: command, frame length, frame address, mask, options, device identifier and a running check value.

Words addressed to the frame-data register are passed on to a frame-write port. Each forwarded word carries the current frame address and its word index within the frame. The index wraps once per frame, and the minor part of the frame address then steps on. Commands found in the stream set mode flags: configuration write enable, drive-high, clock switch and shutdown. A reset-check command clears the check value.

A bad device identifier raises a sticky error that stops all later frame writes until reset. The block is meant to sit between a configuration port and a frame memory controller. Every output is registered and changes one cycle after the word that causes the change.

Top module: `cfg_stream_engine`

## Requirements
- R1: Before the synchronisation word `SYNC_WORD` (0xAA995566) has been received, every word is ignored: registers keep their reset value and no frame write occurs. The word after the sync word is the first one decoded, and `sync_o` stays high until reset.
- R2: After sync, a word whose bits [31:29] are 001 and bits [28:27] are 00 is a no-op (for example 0x20000000). It is skipped, and so is any header that is neither a type-1 write nor a valid type-2 header (for example 0xFFFFFFFF). None of these changes any register.
- R3: A type-1 write header has bits [31:29]=001 and [28:27]=10. Its register address is bits [17:13] and its word count is bits [10:0]. The addresses are: 0 check value, 1 frame address, 2 frame data, 4 command, 6 mask, 9 options, 11 frame length, 14 device ID. Data for any other address is discarded.
- R4: A register data word appears on its output in the cycle after it is accepted.
- R5: A command data word loads bits [4:0] into `cmd_o`. Code 1 sets `wcfg_o`, 7 clears the check value, 8 sets `drive_high_o`, 9 sets `clk_sw_o`, and 11 (0xB) sets `shutdown_o`. The flags stay set until reset.
- R6: Every data word sent to an address other than 0 updates the check value as crc = {crc[30:0],crc[31]} ^ word. This includes frame data, discarded data and command words, and a reset-check command then leaves 0. A data word to address 0 loads the check value directly.
- R7: A device ID data word that differs from `DEVICE_ID` (0x0140D093) sets `id_err_o`, which stays set until reset. A matching word leaves it clear.
- R8: A type-1 write header with count 0 that is immediately followed by a type-2 header (bits [31:29]=010) takes its word count from bits [26:0] of the type-2 header. A type-2 header that does not directly follow such a zero-count header is ignored.
- R9: Frame-data words are forwarded only while `wcfg_o` is set and `id_err_o` is clear. Otherwise they are consumed and dropped.
- R10: A forwarded word drives `fw_valid_o` for one cycle, with `fw_addr_o` set to the current frame address and `fw_idx_o` set to the index. The index counts from 0. After the word at index equal to the frame-length register it returns to 0 and the low `MINOR_W` bits of the frame address increment, wrapping within that field and leaving the upper bits unchanged.
- R11: Writing the frame address register loads the new address and returns the word index to 0.
- R12: `done_o` sets after the last word of a frame-data packet is forwarded, and stays set until reset.
- R13: While a packet's data words are counted, each word is treated as data whatever its value, even if it matches the sync word or a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Word strobe |
| in_word_i | input | 32 | Stream word |
| sync_o | output | 1 | Synchronised |
| id_err_o | output | 1 | Sticky device ID mismatch |
| done_o | output | 1 | Frame-data packet completed |
| cmd_o | output | 5 | Last command code |
| flen_o | output | 32 | Frame length register (length minus one) |
| far_o | output | 32 | Current frame address |
| mask_o | output | 32 | Mask register |
| opt_o | output | 32 | Options register |
| idcode_o | output | 32 | Last device ID word |
| crc_o | output | 32 | Check value |
| wcfg_o | output | 1 | Configuration write enabled |
| drive_high_o | output | 1 | Drive-high command seen |
| clk_sw_o | output | 1 | Clock switch command seen |
| shutdown_o | output | 1 | Shutdown command seen |
| fw_valid_o | output | 1 | Frame write strobe |
| fw_addr_o | output | 32 | Frame address of the write |
| fw_idx_o | output | IDX_W | Word index within the frame |
| fw_data_o | output | 32 | Frame write data |

## Verification
The bench drives the stream in several phases:
- **Before sync.** Header and data words are sent before the sync word, to show that they are ignored.
- **No-op and dummy words.** These are sent after sync to separate skipping from decoding.
- **Frame-data sweep.** Frame-data packets are swept over frame lengths 0 to 3, starting just below the minor-field wrap. The expected index and address are computed as quotient and remainder of the word number, which tests the index wrap, the minor wrap and major preservation together.
- **Look-alike data.** Some data words equal the sync word and a command header, which shows that counted words are never decoded.
- **Long-count path.** Type-2 headers are sent both after a zero-count header and on their own.
- **Blocking and reloads.** Frame data is sent before the write command and after a bad device ID, and the frame address is rewritten in the middle of a frame.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    localparam int CNT_W = 27;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR,
        ST_DATA
    } cfg_state_e;

    typedef enum logic [1:0] {
        HK_NOP,
        HK_WRITE,
        HK_LONG,
        HK_OTHER
    } hdr_kind_e;

    typedef struct packed {
        hdr_kind_e        kind;
        logic [4:0]       addr;
        logic [CNT_W-1:0] cnt;
    } hdr_t;

    // register addresses carried in header bits [17:13]
    localparam logic [4:0] RA_CRC   = 5'd0;
    localparam logic [4:0] RA_FAR   = 5'd1;
    localparam logic [4:0] RA_FDATA = 5'd2;
    localparam logic [4:0] RA_CMD   = 5'd4;
    localparam logic [4:0] RA_MASK  = 5'd6;
    localparam logic [4:0] RA_OPT   = 5'd9;
    localparam logic [4:0] RA_FLEN  = 5'd11;
    localparam logic [4:0] RA_ID    = 5'd14;

    // command codes
    localparam logic [4:0] OP_WCFG  = 5'd1;
    localparam logic [4:0] OP_RCRC  = 5'd7;
    localparam logic [4:0] OP_DRVHI = 5'd8;
    localparam logic [4:0] OP_CLKSW = 5'd9;
    localparam logic [4:0] OP_SHUT  = 5'd11;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w);
        return {c[30:0], c[31]} ^ w;
    endfunction

endpackage

// File: rtl/cfg_hdr_decode.sv
module cfg_hdr_decode
    import cfg_stream_pkg::*;
(
    input  logic [31:0] word_i,
    output hdr_t        hdr_o
);

    always_comb begin
        hdr_o.kind = HK_OTHER;
        hdr_o.addr = word_i[17:13];
        hdr_o.cnt  = '0;
        if (word_i[31:29] == 3'b001) begin
            hdr_o.cnt = CNT_W'(word_i[10:0]);
            if (word_i[28:27] == 2'b00) begin
                hdr_o.kind = HK_NOP;
            end else if (word_i[28:27] == 2'b10) begin
                hdr_o.kind = HK_WRITE;
            end
        end else if (word_i[31:29] == 3'b010) begin
            hdr_o.kind = HK_LONG;
            hdr_o.cnt  = word_i[26:0];
        end
    end

endmodule

// File: rtl/cfg_frame_track.sv
module cfg_frame_track #(
    parameter int IDX_W   = 11,
    parameter int MINOR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [31:0]      far_i,
    input  logic             step_i,
    input  logic [IDX_W-1:0] flen_i,
    output logic [31:0]      far_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic [31:0]      far;
        logic [IDX_W-1:0] idx;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.far = far_i;
            d.idx = '0;
        end else if (step_i) begin
            if (q.idx == flen_i) begin
                d.idx = '0;
                d.far[MINOR_W-1:0] = q.far[MINOR_W-1:0] + 1'b1;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign far_o = q.far;
    assign idx_o = q.idx;

    a_r10_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && idx_o == flen_i) |=> (idx_o == '0));

    a_r10_major_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (far_o[31:MINOR_W] == $past(far_o[31:MINOR_W])));

    a_r11_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (idx_o == '0 && far_o == $past(far_i)));

endmodule

// File: rtl/cfg_stream_engine.sv
module cfg_stream_engine
    import cfg_stream_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD = 32'hAA99_5566,
    parameter logic [31:0] DEVICE_ID = 32'h0140_D093,
    parameter int          IDX_W     = 11,
    parameter int          MINOR_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [31:0]      in_word_i,
    output logic             sync_o,
    output logic             id_err_o,
    output logic             done_o,
    output logic [4:0]       cmd_o,
    output logic [31:0]      flen_o,
    output logic [31:0]      far_o,
    output logic [31:0]      mask_o,
    output logic [31:0]      opt_o,
    output logic [31:0]      idcode_o,
    output logic [31:0]      crc_o,
    output logic             wcfg_o,
    output logic             drive_high_o,
    output logic             clk_sw_o,
    output logic             shutdown_o,
    output logic             fw_valid_o,
    output logic [31:0]      fw_addr_o,
    output logic [IDX_W-1:0] fw_idx_o,
    output logic [31:0]      fw_data_o
);

    typedef struct packed {
        cfg_state_e       st;
        logic             sync;
        logic [4:0]       addr;
        logic [CNT_W-1:0] remain;
        logic             armed;
        logic [4:0]       cmd;
        logic [31:0]      flen;
        logic [31:0]      mask;
        logic [31:0]      opt;
        logic [31:0]      idcode;
        logic [31:0]      crc;
        logic             id_err;
        logic             done;
        logic             wcfg;
        logic             drvhi;
        logic             clksw;
        logic             shut;
        logic             fw_valid;
        logic [31:0]      fw_addr;
        logic [IDX_W-1:0] fw_idx;
        logic [31:0]      fw_data;
    } eng_t;

    eng_t q, d;
    hdr_t hdr;
    logic             trk_load;
    logic             trk_step;
    logic [31:0]      trk_far;
    logic [IDX_W-1:0] trk_idx;

    cfg_hdr_decode u_dec (
        .word_i (in_word_i),
        .hdr_o  (hdr)
    );

    cfg_frame_track #(
        .IDX_W   (IDX_W),
        .MINOR_W (MINOR_W)
    ) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (trk_load),
        .far_i  (in_word_i),
        .step_i (trk_step),
        .flen_i (q.flen[IDX_W-1:0]),
        .far_o  (trk_far),
        .idx_o  (trk_idx)
    );

    always_comb begin
        d          = q;
        d.fw_valid = 1'b0;
        trk_load   = 1'b0;
        trk_step   = 1'b0;
        if (in_valid_i) begin
            case (q.st)
                ST_HUNT: begin
                    if (in_word_i == SYNC_WORD) begin
                        d.sync = 1'b1;
                        d.st   = ST_HDR;
                    end
                end
                ST_HDR: begin
                    d.armed = 1'b0;
                    case (hdr.kind)
                        HK_WRITE: begin
                            d.addr = hdr.addr;
                            if (hdr.cnt == '0) begin
                                d.armed = 1'b1;
                            end else begin
                                d.remain = hdr.cnt;
                                d.st     = ST_DATA;
                            end
                        end
                        HK_LONG: begin
                            if (q.armed && hdr.cnt != '0) begin
                                d.remain = hdr.cnt;
                                d.st     = ST_DATA;
                            end
                        end
                        default: ;
                    endcase
                end
                default: begin
                    d.remain = q.remain - 1'b1;
                    if (q.remain == CNT_W'(1)) d.st = ST_HDR;
                    if (q.addr != RA_CRC) d.crc = crc_step(q.crc, in_word_i);
                    case (q.addr)
                        RA_CRC:  d.crc = in_word_i;
                        RA_FAR:  trk_load = 1'b1;
                        RA_FDATA: begin
                            if (q.wcfg && !q.id_err) begin
                                d.fw_valid = 1'b1;
                                d.fw_addr  = trk_far;
                                d.fw_idx   = trk_idx;
                                d.fw_data  = in_word_i;
                                trk_step   = 1'b1;
                                if (q.remain == CNT_W'(1)) d.done = 1'b1;
                            end
                        end
                        RA_CMD: begin
                            d.cmd = in_word_i[4:0];
                            case (in_word_i[4:0])
                                OP_WCFG:  d.wcfg  = 1'b1;
                                OP_RCRC:  d.crc   = '0;
                                OP_DRVHI: d.drvhi = 1'b1;
                                OP_CLKSW: d.clksw = 1'b1;
                                OP_SHUT:  d.shut  = 1'b1;
                                default: ;
                            endcase
                        end
                        RA_MASK: d.mask = in_word_i;
                        RA_OPT:  d.opt  = in_word_i;
                        RA_FLEN: d.flen = in_word_i;
                        RA_ID: begin
                            d.idcode = in_word_i;
                            if (in_word_i != DEVICE_ID) d.id_err = 1'b1;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign sync_o       = q.sync;
    assign id_err_o     = q.id_err;
    assign done_o       = q.done;
    assign cmd_o        = q.cmd;
    assign flen_o       = q.flen;
    assign far_o        = trk_far;
    assign mask_o       = q.mask;
    assign opt_o        = q.opt;
    assign idcode_o     = q.idcode;
    assign crc_o        = q.crc;
    assign wcfg_o       = q.wcfg;
    assign drive_high_o = q.drvhi;
    assign clk_sw_o     = q.clksw;
    assign shutdown_o   = q.shut;
    assign fw_valid_o   = q.fw_valid;
    assign fw_addr_o    = q.fw_addr;
    assign fw_idx_o     = q.fw_idx;
    assign fw_data_o    = q.fw_data;

    a_r1_no_write_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_o |-> !fw_valid_o);

    a_r1_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> sync_o);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        id_err_o |=> id_err_o);

    a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        id_err_o |-> !fw_valid_o);

    a_r9_needs_wcfg: assert property (@(posedge clk) disable iff (!rst_n)
        fw_valid_o |-> wcfg_o);

    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

endmodule

// File: tb/cfg_stream_engine_test.sv
module cfg_stream_engine_test;

    localparam int IDX_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid_i = 1'b0;
    logic [31:0]      in_word_i = '0;
    logic             sync_o, id_err_o, done_o;
    logic [4:0]       cmd_o;
    logic [31:0]      flen_o, far_o, mask_o, opt_o, idcode_o, crc_o;
    logic             wcfg_o, drive_high_o, clk_sw_o, shutdown_o;
    logic             fw_valid_o;
    logic [31:0]      fw_addr_o;
    logic [IDX_W-1:0] fw_idx_o;
    logic [31:0]      fw_data_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] crc_m = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfg_stream_engine uut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_word_i(in_word_i),
        .sync_o(sync_o), .id_err_o(id_err_o), .done_o(done_o), .cmd_o(cmd_o),
        .flen_o(flen_o), .far_o(far_o), .mask_o(mask_o), .opt_o(opt_o),
        .idcode_o(idcode_o), .crc_o(crc_o), .wcfg_o(wcfg_o),
        .drive_high_o(drive_high_o), .clk_sw_o(clk_sw_o), .shutdown_o(shutdown_o),
        .fw_valid_o(fw_valid_o), .fw_addr_o(fw_addr_o), .fw_idx_o(fw_idx_o),
        .fw_data_o(fw_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one word; returns with outputs of that word settled
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_word_i  = w;
        @(posedge clk);
        #2;
        in_valid_i = 1'b0;
    endtask

    function automatic logic [31:0] hdr1(input logic [4:0] a, input logic [10:0] n);
        return {3'b001, 2'b10, 9'b0, a, 2'b00, n};
    endfunction

    function automatic logic [31:0] rot(input logic [31:0] c, input logic [31:0] w);
        return {c[30:0], c[31]} ^ w;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        send(hdr1(a, 11'd1));
        send(v);
        if (a == 5'd0) crc_m = v;
        else begin
            crc_m = rot(crc_m, v);
            if (a == 5'd4 && v[4:0] == 5'd7) crc_m = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset sync", {31'b0, sync_o}, 0);
        chk("R4 reset crc", crc_o, 0);
        chk("R9 reset fw_valid", {31'b0, fw_valid_o}, 0);

        // R1: pre-sync traffic ignored
        send(32'hFFFF_FFFF);
        send(32'h3000_8001);
        send(32'h0000_0001);
        send(32'h3001_6001);
        send(32'h0000_0005);
        chk("R1 pre-sync cmd", {27'b0, cmd_o}, 0);
        chk("R1 pre-sync flen", flen_o, 0);
        chk("R1 pre-sync wcfg", {31'b0, wcfg_o}, 0);
        chk("R1 pre-sync sync", {31'b0, sync_o}, 0);
        send(32'hAA99_5566);
        chk("R1 sync seen", {31'b0, sync_o}, 1);

        // R2: dummy and no-op skipped
        send(32'hFFFF_FFFF);
        send(32'h2000_0000);
        send(32'h2000_0000);
        chk("R2 skip crc", crc_o, 0);
        chk("R2 skip cmd", {27'b0, cmd_o}, 0);

        // R5 / R4
        wr(5'd4, 32'h0000_0007);
        chk("R5 cmd rcrc", {27'b0, cmd_o}, 7);
        chk("R5 crc cleared", crc_o, 0);
        wr(5'd11, 32'h0000_0002);
        chk("R4 flen", flen_o, 2);
        wr(5'd9, 32'h0000_3FE5);
        chk("R4 options", opt_o, 32'h3FE5);
        wr(5'd6, 32'h0000_A5A5);
        chk("R4 mask", mask_o, 32'hA5A5);
        chk("R6 crc accumulate", crc_o, crc_m);

        // R3: unknown address discarded
        wr(5'd3, 32'h1234_5678);
        chk("R3 unknown mask kept", mask_o, 32'hA5A5);
        chk("R3 unknown opt kept", opt_o, 32'h3FE5);
        chk("R3 unknown flen kept", flen_o, 2);
        chk("R6 crc unknown addr", crc_o, crc_m);

        // R9: frame data before write command dropped
        send(hdr1(5'd2, 11'd2));
        send(32'h1111_1111); crc_m = rot(crc_m, 32'h1111_1111);
        chk("R9 no wcfg drop", {31'b0, fw_valid_o}, 0);
        send(32'h2222_2222); crc_m = rot(crc_m, 32'h2222_2222);
        chk("R9 no wcfg drop2", {31'b0, fw_valid_o}, 0);
        chk("R12 not done", {31'b0, done_o}, 0);
        chk("R6 crc dropped data", crc_o, crc_m);

        // R7 match
        wr(5'd14, 32'h0140_D093);
        chk("R7 id ok", {31'b0, id_err_o}, 0);
        chk("R4 idcode", idcode_o, 32'h0140_D093);

        // R5 commands
        wr(5'd4, 32'h0000_0001);
        chk("R5 wcfg", {31'b0, wcfg_o}, 1);
        wr(5'd4, 32'h0000_0009);
        chk("R5 clk switch", {31'b0, clk_sw_o}, 1);
        wr(5'd4, 32'h0000_0008);
        chk("R5 drive high", {31'b0, drive_high_o}, 1);
        chk("R5 no shutdown yet", {31'b0, shutdown_o}, 0);

        // R10 / R12 / R13 sweep over frame lengths
        for (int f = 0; f < 4; f++) begin
            int n;
            n = (f + 1) * 3 + 1;
            wr(5'd11, f);
            wr(5'd1, 32'h0008_00FD);
            chk("R11 far loaded", far_o, 32'h0008_00FD);
            send(hdr1(5'd2, n[10:0]));
            for (int k = 0; k < n; k++) begin
                logic [31:0] dat;
                logic [7:0]  mn;
                dat = (k == 1) ? 32'hAA99_5566 : (k == 2) ? 32'h3000_8001
                    : {f[7:0], 8'h5A, k[15:0]};
                send(dat);
                crc_m = rot(crc_m, dat);
                mn = 8'hFD + 8'(k / (f + 1));
                chk("R10 fw valid", {31'b0, fw_valid_o}, 1);
                chk("R10 fw idx", {21'b0, fw_idx_o}, k % (f + 1));
                chk("R10 fw addr", fw_addr_o, {24'h0008_00, mn});
                chk("R13 fw data", fw_data_o, dat);
            end
            chk("R12 done", {31'b0, done_o}, 1);
            chk("R13 cmd untouched", {27'b0, cmd_o}, 8);
            chk("R6 crc after frames", crc_o, crc_m);
        end

        // R8 long-count header
        wr(5'd11, 32'd3);
        wr(5'd1, 32'h0000_0000);
        send(32'h3000_4000);
        chk("R8 zero count no write", {31'b0, fw_valid_o}, 0);
        send(32'h5000_0005);
        for (int k = 0; k < 5; k++) begin
            logic [31:0] dat;
            dat = 32'hC0DE_0000 + k;
            send(dat);
            crc_m = rot(crc_m, dat);
            chk("R8 long fw valid", {31'b0, fw_valid_o}, 1);
            chk("R8 long idx", {21'b0, fw_idx_o}, k % 4);
            chk("R8 long addr", fw_addr_o, k / 4);
        end
        send(32'h5000_0002);
        chk("R8 stray long ignored", {31'b0, fw_valid_o}, 0);
        wr(5'd4, 32'h0000_000B);
        chk("R8 header after stray", {31'b0, shutdown_o}, 1);
        chk("R5 shutdown cmd", {27'b0, cmd_o}, 11);

        // R6 direct load
        wr(5'd0, 32'hDEAD_BEEF);
        chk("R6 crc load", crc_o, 32'hDEAD_BEEF);

        // R11 reload mid-frame
        wr(5'd1, 32'h0000_0010);
        send(hdr1(5'd2, 11'd2));
        send(32'h0000_0A01);
        send(32'h0000_0A02);
        chk("R11 mid idx", {21'b0, fw_idx_o}, 1);
        wr(5'd1, 32'h0000_0020);
        send(hdr1(5'd2, 11'd1));
        send(32'h0000_0A03);
        chk("R11 idx restart", {21'b0, fw_idx_o}, 0);
        chk("R11 new addr", fw_addr_o, 32'h20);

        // R7 / R9 mismatch blocks
        wr(5'd14, 32'h1234_5678);
        chk("R7 id mismatch", {31'b0, id_err_o}, 1);
        send(hdr1(5'd2, 11'd2));
        send(32'h0000_0B01);
        chk("R9 blocked after err", {31'b0, fw_valid_o}, 0);
        send(32'h0000_0B02);
        chk("R9 blocked after err2", {31'b0, fw_valid_o}, 0);
        wr(5'd14, 32'h0140_D093);
        chk("R7 err sticky", {31'b0, id_err_o}, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule